// File: doc/BRIEF.md
# Serial Dual-Edge GPIO Bridge

This block moves a small word of general-purpose bits between an external USB microcontroller and the FPGA over three pins. The pins are a slow data clock driven by the microcontroller, a direction line, and one bidirectional data line. The microcontroller puts one bit on the data line for every transition of the data clock, both rising and falling. A fast system clock oversamples all three pins, so it must run at 24 MHz or faster for no edge of the data clock to be missed.

While the direction line is low, the FPGA releases the data line and shifts each received bit into a receive register. When the direction line goes from 0 to 1, the receive register is copied to the parallel output. In the same cycle the parallel input is loaded into a transmit register, which the FPGA then drives onto the data line one bit per data-clock edge. The microcontroller combines returned bits from several sources as a wired-OR. For that reason the transmitter shifts zeros in behind the word, and callers must tie unused input bits to 0.

Top module: `sdg_bridge`

## Requirements
- R1: Every pin passes through a SYNC_STAGES-flop synchronizer. With the default of 2 stages, `word_out` changes on the third rising edge of `clk` after the direction pin rises. After exactly two rising edges it still holds its old value.
- R2: While the synchronized direction is 0, every transition of `link_clk` (rising and falling) shifts the synchronized data bit into the receive register at its LSB end. Bits therefore arrive MSB first.
- R3: `word_out` keeps its value in every cycle except the one in which a rising direction transition is detected, and a reset cycle.
- R4: On a detected 0-to-1 transition of the direction line, `word_out` takes the receive register. This is the last WORD_W bits received, with the most recent bit in bit 0. When fewer bits have been received, the bits above them are those from earlier transfers.
- R5: In the same cycle as R4, `word_in` is loaded into the transmit register. `link_dat` then carries its bit WORD_W-1 and advances one bit toward the LSB on each `link_clk` transition while direction stays 1.
- R6: The transmitter shifts in 0 behind the word, so after WORD_W transitions `link_dat` is driven to 0. Changes on `word_in` after the load have no effect on the bits sent.
- R7: The data-line driver is enabled only while the registered direction is 1. It turns on in the same cycle as the load of R5, and turns off SYNC_STAGES+1 cycles after the direction pin falls. While it is off, a value driven on `link_dat` from outside is read back unchanged.
- R8: Synchronous active-high `rst` clears `word_out`, the receive register and the transmit register. Reset must be held for at least SYNC_STAGES+1 cycles, with `link_clk` steady, so that no transition is detected when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the pins, 24 MHz or faster |
| rst | input | 1 | Synchronous active-high reset |
| link_clk | input | 1 | External data clock; each transition carries one bit |
| link_dir | input | 1 | Direction: 0 receive, 1 transmit; a rise latches and starts transmit |
| link_dat | inout | 1 | Bidirectional serial data line |
| word_in | input | WORD_W | Word returned to the microcontroller |
| word_out | output | WORD_W | Word most recently received |

## Verification
The bench builds the bridge with its defaults: WORD_W of 4 and SYNC_STAGES of 2. With these settings the three-cycle latency of R1 can be checked on exact cycles. Transfers of 4 bits, of more than 4 bits and of fewer than 4 bits are all short enough to run many times. Random words and random bit counts are mixed with directed cases: overlong and short transfers, a reset in the middle of a transfer, a change of `word_in` after the load, and readback of the released data line.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

  typedef enum logic {
    LINK_TO_FPGA   = 1'b0,
    LINK_FROM_FPGA = 1'b1
  } link_dir_e;

  function automatic logic toggled(input logic now_v, input logic prev_v);
    return now_v ^ prev_v;
  endfunction

  function automatic logic rose(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/sdg_sync.sv
module sdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/sdg_front.sv
module sdg_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clk_pin,
  input  logic dir_pin,
  input  logic dat_pin,
  output logic s_dir,
  output logic s_dat,
  output logic dir_q,
  output logic clk_edge,
  output logic dir_rise
);
  import sdg_pkg::*;

  localparam int NPINS = 3;

  logic [NPINS-1:0] raw_pins;
  logic [NPINS-1:0] synced;
  logic             s_clk;
  logic             clk_q;

  assign raw_pins = {dat_pin, dir_pin, clk_pin};

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      sdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (raw_pins[p]),
        .q   (synced[p])
      );
    end
  endgenerate

  assign s_clk = synced[0];
  assign s_dir = synced[1];
  assign s_dat = synced[2];

  // history registers run through reset so that release sees no false edge
  always_ff @(posedge clk) begin
    clk_q <= s_clk;
    dir_q <= s_dir;
  end

  assign clk_edge = toggled(s_clk, clk_q);
  assign dir_rise = rose(s_dir, dir_q);
endmodule

// File: rtl/sdg_shifter.sv
module sdg_shifter #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_dir,
  input  logic              s_dat,
  input  logic              dir_q,
  input  logic              clk_edge,
  input  logic              dir_rise,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] rx_word,
  output logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] word_out
);
  import sdg_pkg::*;

  localparam int MSB = WORD_W - 1;

  logic rx_step;
  logic tx_step;

  assign rx_step = clk_edge && (link_dir_e'(s_dir) == LINK_TO_FPGA);
  assign tx_step = clk_edge && (link_dir_e'(dir_q) == LINK_FROM_FPGA);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
    end else if (rx_step) begin
      rx_word <= {rx_word[MSB-1:0], s_dat};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word  <= '0;
      word_out <= '0;
    end else if (dir_rise) begin
      tx_word  <= word_in;
      word_out <= rx_word;
    end else if (tx_step) begin
      tx_word  <= {tx_word[MSB-1:0], 1'b0};
    end
  end
endmodule

// File: rtl/sdg_bridge.sv
module sdg_bridge #(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_clk,
  input  logic              link_dir,
  inout  wire               link_dat,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out
);
  localparam int MSB = WORD_W - 1;

  logic              s_dir;
  logic              s_dat;
  logic              dir_q;
  logic              clk_edge;
  logic              dir_rise;
  logic              data_oe;
  logic              data_drive;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] tx_word;

  sdg_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .clk_pin  (link_clk),
    .dir_pin  (link_dir),
    .dat_pin  (link_dat),
    .s_dir    (s_dir),
    .s_dat    (s_dat),
    .dir_q    (dir_q),
    .clk_edge (clk_edge),
    .dir_rise (dir_rise)
  );

  sdg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .s_dir    (s_dir),
    .s_dat    (s_dat),
    .dir_q    (dir_q),
    .clk_edge (clk_edge),
    .dir_rise (dir_rise),
    .word_in  (word_in),
    .rx_word  (rx_word),
    .tx_word  (tx_word),
    .word_out (word_out)
  );

  // enable follows the delayed direction so it rises with the transmit load
  assign data_oe    = dir_q;
  assign data_drive = tx_word[MSB];
  assign link_dat   = data_oe ? data_drive : 1'bz;
endmodule

// File: rtl/sdg_bridge_chk.sv
module sdg_bridge_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              s_dir,
  input logic              s_dat,
  input logic              clk_edge,
  input logic              dir_rise,
  input logic              data_oe,
  input logic              data_drive,
  input logic [WORD_W-1:0] rx_word,
  input logic [WORD_W-1:0] tx_word,
  input logic [WORD_W-1:0] word_in,
  input logic [WORD_W-1:0] word_out
);
  localparam int MSB = WORD_W - 1;

  AST_RX_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (clk_edge && !s_dir) |=> rx_word == {$past(rx_word[MSB-1:0]), $past(s_dat)}); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dir_rise |=> $stable(word_out)); // R3

  AST_OUT_LATCH: assert property (@(posedge clk) disable iff (rst)
    dir_rise |=> word_out == $past(rx_word)); // R4

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
    dir_rise |=> tx_word == $past(word_in)); // R5

  AST_TX_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (clk_edge && data_oe && !dir_rise) |=> tx_word == {$past(tx_word[MSB-1:0]), 1'b0}); // R6

  AST_OE_START: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> $past(dir_rise)); // R7

  AST_DRIVE_MSB: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> data_drive == tx_word[MSB]); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (word_out == '0 && rx_word == '0 && tx_word == '0)); // R8
endmodule

bind sdg_bridge sdg_bridge_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .s_dir      (s_dir),
  .s_dat      (s_dat),
  .clk_edge   (clk_edge),
  .dir_rise   (dir_rise),
  .data_oe    (data_oe),
  .data_drive (data_drive),
  .rx_word    (rx_word),
  .tx_word    (tx_word),
  .word_in    (word_in),
  .word_out   (word_out)
);

// File: tb/tb_sdg_bridge.sv
module tb_sdg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int SETTLE     = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         link_clk = 1'b0;
  logic         link_dir = 1'b0;
  logic         host_en = 1'b0;
  logic         host_bit = 1'b0;
  logic [W-1:0] word_in = '0;
  logic [W-1:0] word_out;
  wire          link_dat;

  assign link_dat = host_en ? host_bit : 1'bz;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] rx_model = '0;
  logic [W-1:0] tx_model = '0;
  logic [W-1:0] out_model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdg_bridge #(.WORD_W(W), .SYNC_STAGES(2)) dut (
    .clk      (clk),
    .rst      (rst),
    .link_clk (link_clk),
    .link_dir (link_dir),
    .link_dat (link_dat),
    .word_in  (word_in),
    .word_out (word_out)
  );

  function automatic logic [W-1:0] model_rx(input logic [W-1:0] w, input logic b);
    logic [W-1:0] r;
    r = w << 1;
    r[0] = b;
    return r;
  endfunction

  function automatic logic [W-1:0] model_tx(input logic [W-1:0] w);
    return {w[W-2:0], 1'b0};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    host_bit = b;
    wait_n(2);
    link_clk = ~link_clk;
    wait_n(SETTLE);
    rx_model = model_rx(rx_model, b);
  endtask

  task automatic send_bits(input logic [7:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
  endtask

  task automatic turn_to_fpga(input string req);
    @(negedge clk);
    host_en  = 1'b0;
    link_dir = 1'b1;
    wait_n(2);
    check("R1", word_out, out_model);
    wait_n(1);
    out_model = rx_model;
    tx_model  = word_in;
    check(req, word_out, out_model);
    wait_n(SETTLE);
    check("R5", {{(W-1){1'b0}}, link_dat}, {{(W-1){1'b0}}, tx_model[W-1]});
  endtask

  task automatic read_back(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      link_clk = ~link_clk;
      wait_n(SETTLE);
      tx_model = model_tx(tx_model);
      check(req, {{(W-1){1'b0}}, link_dat}, {{(W-1){1'b0}}, tx_model[W-1]});
    end
  endtask

  task automatic turn_to_host();
    @(negedge clk);
    link_dir = 1'b0;
    wait_n(SETTLE);
    host_en = 1'b1;
  endtask

  initial begin
    int  n;
    logic [7:0] bits;
    void'($urandom(32'd2024));
    wait_n(6);
    rst = 1'b0;
    wait_n(1);
    check("R8", word_out, '0);

    // R7: line released while receiving; host values read back
    host_en = 1'b1;
    host_bit = 1'b1;
    wait_n(2);
    check("R7", {{(W-1){1'b0}}, link_dat}, {{(W-1){1'b0}}, 1'b1});
    host_bit = 1'b0;
    wait_n(2);
    check("R7", {{(W-1){1'b0}}, link_dat}, '0);

    // R2/R4: one full word, both clock edges used
    send_bits(8'h0A, 4);
    check("R3", word_out, out_model);
    word_in = 4'b1011;
    turn_to_fpga("R4");
    read_back(3, "R5");
    read_back(2, "R6");
    turn_to_host();

    // R2: more bits than the word holds
    send_bits(8'b101101, 6);
    word_in = 4'b1100;
    turn_to_fpga("R2");
    word_in = 4'b0011;
    read_back(W, "R6");
    turn_to_host();

    // R4: short transfer keeps older bits
    send_bits(8'b01, 2);
    turn_to_fpga("R4");
    turn_to_host();

    // R8: reset mid transfer clears receive state
    send_bits(8'hF, 4);
    @(negedge clk);
    rst = 1'b1;
    wait_n(5);
    rst = 1'b0;
    rx_model = '0;
    out_model = '0;
    check("R8", word_out, '0);
    word_in = 4'b1001;
    turn_to_fpga("R8");
    read_back(W, "R5");
    turn_to_host();

    // random mix
    for (int k = 0; k < 20; k++) begin
      n = 1 + int'($urandom % 7);
      bits = 8'($urandom);
      send_bits(bits, n);
      check("R3", word_out, out_model);
      word_in = W'($urandom);
      turn_to_fpga("R4");
      word_in = W'($urandom);
      read_back(1 + int'($urandom % 5), "R6");
      turn_to_host();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule